// File: doc/BRIEF.md
# Truncated-Modulus Clock Divider

This block divides a single system clock by any integer ratio from 2 to 16 and produces a divided waveform together with the live count. It is fully synchronous. There is one clock domain, and each stage advances on a one-cycle strobe from the stage before it rather than on a derived clock.

A prescaler counter runs from 0 up to a terminal value and is forced back to 0 at that point instead of running through a full power of two. For an even ratio N, the prescaler counts modulo N/2. A final toggle stage flips at each prescaler wrap, so the output is high for exactly half of every period. For an odd ratio N, the prescaler counts modulo N. A square wave is impossible at an odd ratio, so the output is one count bit chosen by a select input, and an integrator can pick the most balanced bit for the ratio in use.

The ratio and the bit select are captured during reset and at the end of every output period. A new setting therefore never cuts a period short.

Top module: `trunc_clk_div`

## Requirements
- R1: While `rstN` is low at a rising clock edge, the count and the toggle stage clear to 0, so `countOut` and `divOut` read 0 after that edge, and the ratio and select inputs are captured.
- R2: For an even ratio N from 4 to 16, `countOut` steps 0, 1, …, N/2−1 on successive edges and then returns to 0.
- R3: For an even ratio N, `divOut` is low for the first N/2 cycles of each period and high for the next N/2, starting low after reset.
- R4: For an odd ratio N, `countOut` steps 0, 1, …, N−1 and then returns to 0.
- R5: For an odd ratio, `divOut` equals bit k of `countOut`, where k is the captured `oddBitSel` value (0 selects the least significant bit, 3 the most significant).
- R6: At ratio 2, `countOut` stays at 0 and `divOut` inverts on every edge, starting low.
- R7: A change on `divRatio` or `oddBitSel` takes effect only at the edge that ends the current output period. The output period is N cycles counted from the last reset or the last capture. Until that edge, count and output follow the old setting.
- R8: A `divRatio` value below 2 is used as 2, and a value above 16 is used as 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| divRatio | input | 5 | Requested divide ratio (2 to 16, clamped) |
| oddBitSel | input | 2 | Count bit index that drives the output at odd ratios |
| countOut | output | 4 | Current prescaler count |
| divOut | output | 1 | Divided output waveform |

## Verification
Both outputs are decoded from registers that move on the rising edge. The count and the toggle stage change one edge after the cycle that causes them, and a reset shows on the outputs after the first low edge. A new ratio or select first appears on the edge that closes the running period, and the count reads 0 there.

The bench drives inputs and samples outputs on the falling edge. It advances an arithmetic model (phase within the period, ratio, select) once per rising edge, and it reads the model's pending inputs at exactly the edge where the period ends. Every sampled value therefore corresponds to a whole number of edges since reset.

// File: rtl/tcd_pkg.sv
package tcd_pkg;
  // Strobes from the control to the datapath, valid for one cycle.
  typedef struct packed {
    logic wrap;  // prescaler at its terminal count: return to zero
    logic flip;  // even ratio and prescaler wrapping: invert toggle stage
  } tcdStrobe_t;
endpackage

// File: rtl/tcd_ctrl.sv
module tcd_ctrl
  import tcd_pkg::*;
#(
  parameter int MIN_RATIO = 2,
  parameter int MAX_RATIO = 16,
  parameter int RATIO_W   = $clog2(MAX_RATIO + 1),
  parameter int CNT_W     = $clog2(MAX_RATIO),
  parameter int SEL_W     = $clog2(CNT_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [RATIO_W-1:0] divRatio,
  input  logic [SEL_W-1:0]   oddBitSel,
  input  logic [CNT_W-1:0]   countIn,
  input  logic               toggleIn,
  output tcdStrobe_t         strobe,
  output logic               isEven,
  output logic [SEL_W-1:0]   activeSel
);

  localparam logic [RATIO_W-1:0] LO_LIM = RATIO_W'(MIN_RATIO);
  localparam logic [RATIO_W-1:0] HI_LIM = RATIO_W'(MAX_RATIO);

  logic [RATIO_W-1:0] activeRatio;
  logic [RATIO_W-1:0] modulus;
  logic [RATIO_W-1:0] termCnt;
  logic               atTerm;
  logic               periodEnd;

  function automatic logic [RATIO_W-1:0] clampRatio(input logic [RATIO_W-1:0] req);
    if (req < LO_LIM)      return LO_LIM;
    else if (req > HI_LIM) return HI_LIM;
    else                   return req;
  endfunction

  always_comb begin
    isEven    = ~activeRatio[0];
    modulus   = isEven ? (activeRatio >> 1) : activeRatio;
    termCnt   = modulus - RATIO_W'(1);
    atTerm    = (RATIO_W'(countIn) == termCnt);
    // A full output period ends at the prescaler wrap for odd ratios,
    // and at the wrap that returns the toggle stage low for even ratios.
    periodEnd = atTerm & (~isEven | toggleIn);
    strobe.wrap = atTerm;
    strobe.flip = atTerm & isEven;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeRatio <= clampRatio(divRatio);
      activeSel   <= oddBitSel;
    end else if (periodEnd) begin
      activeRatio <= clampRatio(divRatio);
      activeSel   <= oddBitSel;
    end
  end

  a_r8_ratio_range: assert property (@(posedge clk) disable iff (!rstN)
    (activeRatio >= LO_LIM) && (activeRatio <= HI_LIM));

  a_r7_hold_config: assert property (@(posedge clk) disable iff (!rstN)
    !periodEnd |=> ($stable(activeRatio) && $stable(activeSel)));

  a_r4_odd_toggle_idle: assert property (@(posedge clk) disable iff (!rstN)
    !isEven |-> !toggleIn);

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    RATIO_W'(countIn) <= termCnt);

endmodule

// File: rtl/tcd_datapath.sv
module tcd_datapath
  import tcd_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int SEL_W = $clog2(CNT_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  tcdStrobe_t       strobe,
  input  logic             isEven,
  input  logic [SEL_W-1:0] bitSel,
  output logic [CNT_W-1:0] count,
  output logic             toggle,
  output logic             divOut
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count  <= '0;
      toggle <= 1'b0;
    end else begin
      count <= strobe.wrap ? '0 : count + CNT_W'(1);
      if (strobe.flip) toggle <= ~toggle;
    end
  end

  always_comb begin
    divOut = isEven ? toggle : count[bitSel];
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |=> ((count == '0) && !toggle));

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (count != '0) |-> (count == $past(count) + CNT_W'(1)));

  a_r3_toggle_at_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (toggle != $past(toggle)) |-> (count == '0));

endmodule

// File: rtl/trunc_clk_div.sv
module trunc_clk_div
  import tcd_pkg::*;
#(
  parameter int MIN_RATIO = 2,
  parameter int MAX_RATIO = 16,
  parameter int RATIO_W   = $clog2(MAX_RATIO + 1),
  parameter int CNT_W     = $clog2(MAX_RATIO),
  parameter int SEL_W     = $clog2(CNT_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [RATIO_W-1:0] divRatio,
  input  logic [SEL_W-1:0]   oddBitSel,
  output logic [CNT_W-1:0]   countOut,
  output logic               divOut
);

  tcdStrobe_t       strobe;
  logic             isEven;
  logic [SEL_W-1:0] activeSel;
  logic             toggle;

  tcd_ctrl #(
    .MIN_RATIO(MIN_RATIO), .MAX_RATIO(MAX_RATIO),
    .RATIO_W(RATIO_W), .CNT_W(CNT_W), .SEL_W(SEL_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .divRatio(divRatio), .oddBitSel(oddBitSel),
    .countIn(countOut), .toggleIn(toggle), .strobe(strobe),
    .isEven(isEven), .activeSel(activeSel)
  );

  tcd_datapath #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .isEven(isEven),
    .bitSel(activeSel), .count(countOut), .toggle(toggle), .divOut(divOut)
  );

endmodule

// File: tb/trunc_clk_div_bench.sv
`timescale 1ns/1ps
module trunc_clk_div_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] divRatio = 5'd2;
  logic [1:0] oddBitSel = 2'd0;
  logic [3:0] countOut;
  logic       divOut;

  int nChecks = 0;
  int nErrors = 0;
  int mN = 2, mPhase = 0, mSel = 0;

  always #2.5 clk = ~clk;

  trunc_clk_div u_trunc_clk_div (
    .clk(clk), .rstN(rstN), .divRatio(divRatio), .oddBitSel(oddBitSel),
    .countOut(countOut), .divOut(divOut)
  );

  function automatic int clampR(input int r);
    if (r < 2)  return 2;
    if (r > 16) return 16;
    return r;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s %s actual=%0d expected=%0d (ratio %0d phase %0d)",
               tag, what, act, exp, mN, mPhase);
    end
  endtask

  task automatic checkNow(input string tagC, input string tagO);
    int m, expC, expO;
    m    = (mN % 2 == 0) ? mN / 2 : mN;
    expC = mPhase % m;
    expO = (mN % 2 == 0) ? int'(mPhase >= m) : ((mPhase >> mSel) & 1);
    chk(tagC, "countOut", int'(countOut), expC);
    chk(tagO, "divOut", int'(divOut), expO);
  endtask

  // One rising edge: the model captures pending inputs at the period end.
  task automatic stepCycle();
    @(posedge clk);
    if (mPhase == mN - 1) begin
      mN = clampR(int'(divRatio));
      mSel = int'(oddBitSel);
      mPhase = 0;
    end else begin
      mPhase++;
    end
    @(negedge clk);
  endtask

  task automatic runCycles(input int n, input string tagC, input string tagO);
    for (int i = 0; i < n; i++) begin
      checkNow(tagC, tagO);
      stepCycle();
    end
  endtask

  task automatic doReset(input int r, input int s);
    rstN = 1'b0;
    divRatio = 5'(r);
    oddBitSel = 2'(s);
    @(posedge clk); @(negedge clk);
    chk("R1", "countOut in reset", int'(countOut), 0);
    chk("R1", "divOut in reset", int'(divOut), 0);
    @(posedge clk); @(negedge clk);
    rstN = 1'b1;
    mN = clampR(r);
    mSel = s;
    mPhase = 0;
  endtask

  initial begin
    #(200000 * 5);
    nErrors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    @(negedge clk);
    // Sweep every ratio, every select for odd ratios (R2..R6).
    for (int r = 2; r <= 16; r++) begin
      for (int s = 0; s < ((r % 2 == 1) ? 4 : 1); s++) begin
        int highs;
        string tc, to;
        tc = (r == 2) ? "R6" : ((r % 2 == 0) ? "R2" : "R4");
        to = (r == 2) ? "R6" : ((r % 2 == 0) ? "R3" : "R5");
        doReset(r, s);
        highs = 0;
        for (int i = 0; i < 3 * r; i++) begin
          if (i < r) highs += int'(divOut);
          checkNow(tc, to);
          stepCycle();
        end
        if (r % 2 == 0) chk("R3", "high cycles per period", highs, r / 2);
      end
    end

    // Settings changed mid-period wait for the period end (R7).
    doReset(6, 0);
    runCycles(4, "R7", "R7");
    divRatio = 5'd5; oddBitSel = 2'd1;
    runCycles(12, "R7", "R7");
    divRatio = 5'd12;
    runCycles(3, "R7", "R7");
    divRatio = 5'd9; oddBitSel = 2'd2;
    runCycles(30, "R7", "R7");
    divRatio = 5'd16;
    runCycles(40, "R7", "R7");
    divRatio = 5'd7; oddBitSel = 2'd0;
    runCycles(20, "R7", "R7");
    oddBitSel = 2'd2;
    runCycles(20, "R7", "R7");

    // Out-of-range ratios are clamped (R8).
    doReset(0, 0);
    runCycles(6, "R8", "R8");
    doReset(1, 0);
    runCycles(6, "R8", "R8");
    doReset(31, 0);
    runCycles(40, "R8", "R8");
    divRatio = 5'd17;
    runCycles(40, "R8", "R8");
    divRatio = 5'd0;
    runCycles(20, "R8", "R8");

    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

endmodule